// File: doc/BRIEF.md
# Complementary PWM Burst Generator

This block drives a complementary pair of edge-aligned PWM outputs and emits a programmed number of whole PWM periods on request. A period counter runs freely from reset. Software writes a burst length and pulses `start`. The burst then begins at the next period boundary. A one-shot cycle counter counts the period boundaries that pass while the burst runs. When the count reaches the programmed length, a sticky stop flag is latched. That flag acts as an active-high fault: it takes both outputs low at once, so no partial or extra period leaks out after the last one.

The two outputs are complementary. `pwm_b` follows the inverse of the raw A waveform, and a programmable dead band is inserted after every transition, during which both outputs stay low. Period, duty and dead time are held in shadow registers that are reloaded only at a period boundary, so writes made part-way through a period take effect cleanly at the next one. A one-clock `done` pulse marks the end of a burst. Before another burst can start, the stop flag must be cleared with `clear`.

Top module: `pwm_burst_gen`

## Requirements
- R1: During and immediately after reset, `pwm_a`, `pwm_b` and `done` are low.
- R2: The period is `cfg_period` clocks; a value of 0 or 1 gives a one-clock period. Within each period the raw A waveform is high for the first `cfg_duty` clocks (edge-aligned). A duty of 0 keeps A low, and a duty at or above the period keeps A high.
- R3: `pwm_b` follows the inverse of the raw A waveform. After every raw transition, both outputs are held low for `cfg_dead` clocks. The two outputs are never high together.
- R4: Period, duty and dead time are sampled only at a period boundary (the last clock of a period). A write made inside a period does not change that period.
- R5: A `start` pulse arms the block. The burst begins at the next period boundary and runs exactly `cfg_burst` (sampled at `start`) whole periods; a length of 0 behaves as 1.
- R6: At the end of the last period, the stop flag is set. From the next clock, both outputs are low and stay low while the flag is set.
- R7: `done` is high for exactly one clock, in the cycle the stop flag becomes set.
- R8: `start` is ignored while the block is armed, running, or has its stop flag set. This includes a `start` given in the same cycle as `clear`.
- R9: `clear` resets the stop flag, after which `start` runs a new burst. If `clear` arrives in the same cycle as the terminal period boundary, the stop wins and the flag is set.
- R10: Outside a burst (idle or armed), both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Period length in clocks |
| cfg_duty | input | CNT_W | High time of raw A in clocks |
| cfg_dead | input | DT_W | Dead band in clocks after each transition |
| cfg_burst | input | BURST_W | Number of periods per burst |
| start | input | 1 | Pulse: arm a burst |
| clear | input | 1 | Pulse: clear the stop flag |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | Complementary PWM output B |
| done | output | 1 | One-clock pulse at the end of a burst |

## Verification
Two events can fall in the same cycle: a software `clear` of the stop flag and the terminal period boundary that sets it. The bench tracks its reference model and raises `clear` exactly on the clock whose edge ends the last period. It then judges that `done` fires, that the outputs stay low, and that a later `start` produces no PWM edge, which shows the flag survived. A second collision, `start` given together with `clear` while the flag is set, is provoked in the same way and must yield no burst.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_ARMED = 2'd1,
        BST_RUN   = 2'd2
    } burst_state_e;

endpackage

// File: rtl/pwm_burst_timebase.sv
module pwm_burst_timebase #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    input  logic [DT_W-1:0]  cfg_dead,
    output logic             wrap,
    output logic             raw_a,
    output logic [DT_W-1:0]  dead
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DT_W-1:0]  dead;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        wrap    = (cnt_inc >= {1'b0, st_q.per});
        raw_a   = (st_q.cnt < st_q.duty);
        dead    = st_q.dead;
        st_d    = st_q;
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.per  = cfg_period;
            st_d.duty = cfg_duty;
            st_d.dead = cfg_dead;
        end else begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.per != '0) |-> (st_q.cnt < st_q.per));

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> ($stable(st_q.per) && $stable(st_q.duty) && $stable(st_q.dead)));
endmodule

// File: rtl/pwm_burst_ctrl.sv
module pwm_burst_ctrl
    import pwm_burst_pkg::*;
#(
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               clear,
    input  logic               wrap,
    input  logic [BURST_W-1:0] cfg_burst,
    output logic               run,
    output logic               stop_flag,
    output logic               done
);
    typedef struct packed {
        burst_state_e       state;
        logic               flag;
        logic               done;
        logic [BURST_W-1:0] len;
        logic [BURST_W-1:0] cnt;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic [BURST_W:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_inc   = {1'b0, st_q.cnt} + {{BURST_W{1'b0}}, 1'b1};
        if (clear) st_d.flag = 1'b0;
        case (st_q.state)
            BST_IDLE: begin
                if (start && !st_q.flag) begin
                    st_d.state = BST_ARMED;
                    st_d.len   = cfg_burst;
                end
            end
            BST_ARMED: begin
                if (wrap) begin
                    st_d.state = BST_RUN;
                    st_d.cnt   = '0;
                end
            end
            BST_RUN: begin
                if (wrap) begin
                    st_d.cnt = cnt_inc[BURST_W-1:0];
                    if (cnt_inc >= {1'b0, st_q.len}) begin
                        st_d.state = BST_IDLE;
                        st_d.flag  = 1'b1;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d.state = BST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= BST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign run       = (st_q.state == BST_RUN);
    assign stop_flag = st_q.flag;
    assign done      = st_q.done;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R7
    done_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $rose(st_q.flag));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && start) |=> (st_q.state == BST_IDLE));

    // R6
    flag_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> (st_q.state != BST_RUN));
endmodule

// File: rtl/pwm_burst_deadband.sv
module pwm_burst_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            raw_a,
    input  logic [DT_W-1:0] dead,
    output logic            out_a,
    output logic            out_b
);
    typedef struct packed {
        logic            prev;
        logic [DT_W-1:0] age;
        logic            oa;
        logic            ob;
    } db_state_t;

    db_state_t st_d, st_q;
    logic settled;

    always_comb begin
        st_d.prev = raw_a;
        if (raw_a != st_q.prev)  st_d.age = '0;
        else if (&st_q.age)      st_d.age = st_q.age;
        else                     st_d.age = st_q.age + 1'b1;
        settled = (st_d.age >= dead);
        st_d.oa = enable && raw_a && settled;
        st_d.ob = enable && !raw_a && settled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_a = st_q.oa;
    assign out_b = st_q.ob;

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.oa && st_q.ob));

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!st_q.oa && !st_q.ob));
endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen #(
    parameter int CNT_W   = 16,
    parameter int DT_W    = 8,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_period,
    input  logic [CNT_W-1:0]   cfg_duty,
    input  logic [DT_W-1:0]    cfg_dead,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic               start,
    input  logic               clear,
    output logic               pwm_a,
    output logic               pwm_b,
    output logic               done
);
    logic            wrap;
    logic            raw_a;
    logic [DT_W-1:0] dead;
    logic            run;
    logic            stop_flag;

    pwm_burst_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .cfg_duty   (cfg_duty),
        .cfg_dead   (cfg_dead),
        .wrap       (wrap),
        .raw_a      (raw_a),
        .dead       (dead)
    );

    pwm_burst_ctrl #(.BURST_W(BURST_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear     (clear),
        .wrap      (wrap),
        .cfg_burst (cfg_burst),
        .run       (run),
        .stop_flag (stop_flag),
        .done      (done)
    );

    pwm_burst_deadband #(.DT_W(DT_W)) u_deadband (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run),
        .raw_a  (raw_a),
        .dead   (dead),
        .out_a  (pwm_a),
        .out_b  (pwm_b)
    );

    // R6
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |=> (!pwm_a && !pwm_b));

    // R9
    stop_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> stop_flag);
endmodule

// File: tb/pwm_burst_gen_bench.sv
module pwm_burst_gen_bench;
    localparam int CNT_W   = 16;
    localparam int DT_W    = 8;
    localparam int BURST_W = 8;
    localparam int DT_MAX  = (1 << DT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CNT_W-1:0]   cfg_period = '0;
    logic [CNT_W-1:0]   cfg_duty = '0;
    logic [DT_W-1:0]    cfg_dead = '0;
    logic [BURST_W-1:0] cfg_burst = '0;
    logic               start = 1'b0;
    logic               clear = 1'b0;
    logic               pwm_a, pwm_b, done;

    pwm_burst_gen #(.CNT_W(CNT_W), .DT_W(DT_W), .BURST_W(BURST_W)) u_pwm_burst_gen (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_duty(cfg_duty),
        .cfg_dead(cfg_dead), .cfg_burst(cfg_burst), .start(start), .clear(clear),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .done(done)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rises_a = 0;
    int rises_b = 0;
    int dones = 0;
    logic last_a = 1'b0, last_b = 1'b0;

    // behavioural reference model
    int  m_cnt, m_per, m_duty, m_dead, m_age, m_len, m_done_k;
    bit  m_arm, m_run, m_flag, m_prev, m_oa, m_ob, m_done;

    always @(posedge clk) begin
        bit wr, raw, n_run, n_arm, n_flag;
        int n_age, n_k;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_dead = 0; m_age = 0; m_len = 0;
            m_done_k = 0; m_arm = 0; m_run = 0; m_flag = 0; m_prev = 0;
            m_oa = 0; m_ob = 0; m_done = 0;
        end else begin
            wr  = (m_cnt + 1 >= m_per);
            raw = (m_cnt < m_duty);
            n_age = (raw != m_prev) ? 0 : ((m_age < DT_MAX) ? m_age + 1 : m_age);
            m_oa = m_run && raw && (n_age >= m_dead);
            m_ob = m_run && !raw && (n_age >= m_dead);
            m_prev = raw; m_age = n_age;
            n_run = m_run; n_arm = m_arm; n_flag = m_flag; n_k = m_done_k;
            m_done = 0;
            if (clear) n_flag = 0;
            if (start && !m_flag && !m_arm && !m_run) begin
                n_arm = 1; m_len = int'(cfg_burst);
            end
            if (m_arm && wr) begin n_run = 1; n_arm = 0; n_k = 0; end
            if (m_run && wr) begin
                n_k = m_done_k + 1;
                if (n_k >= m_len) begin n_run = 0; n_flag = 1; m_done = 1; end
            end
            m_run = n_run; m_arm = n_arm; m_flag = n_flag; m_done_k = n_k;
            if (wr) begin
                m_cnt = 0; m_per = int'(cfg_period); m_duty = int'(cfg_duty);
                m_dead = int'(cfg_dead);
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // per-clock comparison (R2, R3, R6, R7, R10 through the model)
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (rst_n) begin
            checks = checks + 1;
            if (pwm_a !== m_oa || pwm_b !== m_ob || done !== m_done) begin
                errors = errors + 1;
                $display("FAIL R2/R3 cycle %0d: a=%b b=%b done=%b expected a=%b b=%b done=%b",
                         cycles, pwm_a, pwm_b, done, m_oa, m_ob, m_done);
            end
            if (pwm_a && !last_a) rises_a = rises_a + 1;
            if (pwm_b && !last_b) rises_b = rises_b + 1;
            if (done) dones = dones + 1;
        end
        last_a = pwm_a; last_b = pwm_b;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clear_then_start();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic setup(input int p, input int d, input int dt, input int n);
        @(negedge clk);
        cfg_period = CNT_W'(p); cfg_duty = CNT_W'(d);
        cfg_dead = DT_W'(dt); cfg_burst = BURST_W'(n);
        rises_a = 0; rises_b = 0; dones = 0;
    endtask

    initial begin
        idle(4);
        // R1
        check("R1 pwm_a in reset", int'(pwm_a), 0);
        check("R1 done in reset", int'(done), 0);
        @(negedge clk); rst_n = 1'b1;
        check("R1 pwm_b after reset", int'(pwm_b), 0);

        // R5 basic burst of 3; R10 idle low while armed
        setup(10, 4, 2, 3);
        idle(12);
        pulse_clear_then_start();
        check("R10 armed outputs low", int'(pwm_a | pwm_b), 0);
        wait_done();
        idle(3);
        check("R5 three periods on A", rises_a, 3);
        check("R7 one done pulse", dones, 1);
        rises_a = 0; rises_b = 0;
        idle(40);
        // R6
        check("R6 no edges after stop", rises_a + rises_b, 0);

        // R8 start while flag set
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle(40);
        check("R8 start ignored while stopped", rises_a + rises_b, 0);
        // R8 start together with clear
        @(negedge clk); start = 1'b1; clear = 1'b1;
        @(negedge clk); start = 1'b0; clear = 1'b0;
        idle(40);
        check("R8 start with clear ignored", rises_a + rises_b, 0);

        // R9 rerun, R4 mid-burst reconfiguration
        setup(10, 4, 1, 5);
        pulse_clear_then_start();
        idle(17);
        cfg_period = CNT_W'(12); cfg_duty = CNT_W'(7);
        wait_done();
        idle(3);
        check("R9 R4 five periods after rearm", rises_a, 5);

        // R2 zero duty: B constantly on for the burst
        setup(8, 0, 1, 2);
        pulse_clear_then_start();
        wait_done();
        idle(3);
        check("R2 zero duty A silent", rises_a, 0);
        check("R3 zero duty B one pulse", rises_b, 1);

        // R2 duty at period: A constantly on
        setup(6, 9, 0, 2);
        pulse_clear_then_start();
        wait_done();
        idle(3);
        check("R2 full duty A one pulse", rises_a, 1);
        check("R2 full duty B silent", rises_b, 0);

        // R5 zero length behaves as one
        setup(9, 3, 1, 0);
        pulse_clear_then_start();
        wait_done();
        idle(3);
        check("R5 zero length gives one period", rises_a, 1);

        // R9 clear coincides with terminal boundary
        setup(7, 3, 1, 2);
        pulse_clear_then_start();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (m_run && (m_cnt + 1 >= m_per) && (m_done_k + 1 >= m_len)) break;
        end
        clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        check("R9 done on collision", int'(done), 1);
        rises_a = 0; rises_b = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle(40);
        check("R9 flag kept over clear", rises_a + rises_b, 0);

        // R5 long burst
        setup(4, 2, 0, 99);
        pulse_clear_then_start();
        wait_done();
        idle(3);
        check("R5 ninety-nine periods", rises_a, 99);
        check("R3 B pulses in long burst", rises_b, 99);

        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule